// File: doc/BRIEF.md
# Shared Storage Bus Enable Controller

This controller decides, from an external enable level, whether a USB-to-storage bridge may drive its storage-side pins and whether it stays attached to the USB host. The enable comes from outside the chip and may change at any time. It passes through a two-flop synchroniser. A free-running period timer then samples it once every `TICK_CYCLES` clocks, which is 20 ms at a 24 MHz core clock. Between sampling instants the enable has no effect.

The controller has three modes. In run mode the bridge is connected and drives the bus whenever enable is high. A low sample in run mode drops the USB connection and enters an enable-caused low-power mode. A later high sample leaves that mode with a one-cycle soft-reset pulse and a reconnect request, provided no other low-power cause is present. While the host holds the bridge in suspend, a sample that disagrees with the current drive state opens a short wake window. The window turns the bus drivers off or on, and then the block falls back to low power without touching the USB connection.

Top module: `busshare_ctl`

## Requirements
- R1: During and right after a synchronous reset: `bus_oe`=0, `engine_halt`=1, `usb_connect`=1, `lowpower_req`=0, `soft_reset`=0, `wake_req`=0.
- R2: The enable is acted on only at sampling instants, one every `TICK_CYCLES` clocks after reset. The first instant falls `TICK_CYCLES`+1 edges after reset release, so a high enable at reset turns `bus_oe` on only then.
- R3: While `mfg_mode` is 1, samples are skipped and the drive and connect outputs hold their values.
- R4: `engine_halt` is always the inverse of `bus_oe`. The bus is never driven while the storage engine is halted.
- R5: A low sample in run mode without suspend sets `bus_oe`=0, `usb_connect`=0 and `lowpower_req`=1.
- R6: In enable-caused low power, a high sample with `other_lp_cause`=0 gives exactly one `soft_reset` cycle and sets `usb_connect`=1, `bus_oe`=1 and `lowpower_req`=0.
- R7: In enable-caused low power, a high sample with `other_lp_cause`=1 leaves every output unchanged.
- R8: While `suspend_in`=1 in run mode, a sample whose level differs from `bus_oe` raises `wake_req` for exactly `WAKE_CYCLES` cycles. During that window `bus_oe` takes the sampled level, `usb_connect` stays 1 and `lowpower_req` is 0. `lowpower_req` returns to 1 afterwards.
- R9: While suspended, a sample equal to the current drive state causes no wake. In run mode `lowpower_req` follows `suspend_in` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| share_en_in | input | 1 | Asynchronous bus-share enable, active high |
| mfg_mode | input | 1 | Manufacturing mode, suppresses sampling |
| suspend_in | input | 1 | Host suspend indication |
| other_lp_cause | input | 1 | Another reason to stay in low power |
| bus_oe | output | 1 | Storage-bus output enable |
| engine_halt | output | 1 | Halt for the storage state machine |
| usb_connect | output | 1 | USB attach request |
| lowpower_req | output | 1 | Low-power request |
| soft_reset | output | 1 | One-cycle soft-reset pulse |
| wake_req | output | 1 | Brief self-wake window during suspend |

## Verification
An enable change reaches the synchroniser output two edges later. It is acted on at the edge that follows the next timer tick, and the registered outputs change at that edge. After each stimulus the driver waits two full sampling periods plus margin before it queues its expected output set, so the result is due well before the monitor compares it, whatever the tick phase. The first sample after reset is checked on exact edge counts, five cycles before and five cycles after the expected instant. `lowpower_req` follows `suspend_in` one edge later. `wake_req` and `soft_reset` are measured by counting high cycles from rise to fall.

// File: rtl/busshare_pkg.sv
package busshare_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_LOWP = 2'd1,
    MODE_WAKE = 2'd2
  } mode_t;
endpackage

// File: rtl/busshare_sync.sv
module busshare_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/busshare_tick.sv
module busshare_tick #(
  parameter int PERIOD = 480000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/busshare_mode.sv
module busshare_mode
  import busshare_pkg::*;
#(
  parameter int WAKE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sample,
  input  logic en_s,
  input  logic suspend_in,
  input  logic other_lp_cause,
  output logic bus_oe,
  output logic engine_halt,
  output logic usb_connect,
  output logic lowpower_req,
  output logic soft_reset,
  output logic wake_req
);
  localparam int WW = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
  localparam logic [WW-1:0] WLAST = WW'(WAKE_CYCLES - 1);

  mode_t         mode;
  logic [WW-1:0] wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode         <= MODE_RUN;
      wcnt         <= '0;
      bus_oe       <= 1'b0;
      engine_halt  <= 1'b1;
      usb_connect  <= 1'b1;
      lowpower_req <= 1'b0;
      soft_reset   <= 1'b0;
      wake_req     <= 1'b0;
    end else begin
      soft_reset <= 1'b0;
      case (mode)
        MODE_RUN: begin
          lowpower_req <= suspend_in;
          if (sample) begin
            if (suspend_in) begin
              if (en_s != bus_oe) begin
                mode         <= MODE_WAKE;
                wcnt         <= WLAST;
                wake_req     <= 1'b1;
                lowpower_req <= 1'b0;
                bus_oe       <= en_s;
                engine_halt  <= ~en_s;
              end
            end else if (!en_s) begin
              mode         <= MODE_LOWP;
              bus_oe       <= 1'b0;
              engine_halt  <= 1'b1;
              usb_connect  <= 1'b0;
              lowpower_req <= 1'b1;
            end else begin
              bus_oe      <= 1'b1;
              engine_halt <= 1'b0;
            end
          end
        end
        MODE_LOWP: begin
          if (sample && en_s && !other_lp_cause) begin
            mode         <= MODE_RUN;
            soft_reset   <= 1'b1;
            usb_connect  <= 1'b1;
            bus_oe       <= 1'b1;
            engine_halt  <= 1'b0;
            lowpower_req <= 1'b0;
          end
        end
        MODE_WAKE: begin
          if (wcnt == '0) begin
            mode         <= MODE_RUN;
            wake_req     <= 1'b0;
            lowpower_req <= suspend_in;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        default: mode <= MODE_RUN;
      endcase
    end
  end
endmodule

// File: rtl/busshare_ctl.sv
module busshare_ctl #(
  parameter int TICK_CYCLES = 480000,
  parameter int WAKE_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic share_en_in,
  input  logic mfg_mode,
  input  logic suspend_in,
  input  logic other_lp_cause,
  output logic bus_oe,
  output logic engine_halt,
  output logic usb_connect,
  output logic lowpower_req,
  output logic soft_reset,
  output logic wake_req
);
  logic en_s;
  logic samp_tick;
  logic sample;

  busshare_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(share_en_in), .q_sync(en_s)
  );

  busshare_tick #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .tick(samp_tick)
  );

  assign sample = samp_tick & ~mfg_mode;

  busshare_mode #(.WAKE_CYCLES(WAKE_CYCLES)) u_mode (
    .clk(clk), .rst(rst), .sample(sample), .en_s(en_s),
    .suspend_in(suspend_in), .other_lp_cause(other_lp_cause),
    .bus_oe(bus_oe), .engine_halt(engine_halt), .usb_connect(usb_connect),
    .lowpower_req(lowpower_req), .soft_reset(soft_reset), .wake_req(wake_req)
  );
endmodule

// File: rtl/busshare_ctl_chk.sv
module busshare_ctl_chk (
  input logic clk,
  input logic rst,
  input logic samp_tick,
  input logic mfg_mode,
  input logic bus_oe,
  input logic engine_halt,
  input logic usb_connect,
  input logic lowpower_req,
  input logic soft_reset,
  input logic wake_req
);
  assert_halt_inverse_R4: assert property (@(posedge clk) disable iff (rst)
    engine_halt == !bus_oe);

  assert_drive_only_at_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(samp_tick) |-> $stable(bus_oe));

  assert_mfg_holds_R3: assert property (@(posedge clk) disable iff (rst)
    $past(mfg_mode) |-> ($stable(bus_oe) && $stable(usb_connect)));

  assert_disconnect_state_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(usb_connect) |-> (!bus_oe && lowpower_req));

  assert_softreset_single_R6: assert property (@(posedge clk) disable iff (rst)
    soft_reset |=> !soft_reset);

  assert_softreset_outputs_R6: assert property (@(posedge clk) disable iff (rst)
    soft_reset |-> (usb_connect && bus_oe && !lowpower_req));

  assert_wake_awake_R8: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> (!lowpower_req && usb_connect));
endmodule

bind busshare_ctl busshare_ctl_chk u_chk (
  .clk(clk), .rst(rst), .samp_tick(samp_tick), .mfg_mode(mfg_mode),
  .bus_oe(bus_oe), .engine_halt(engine_halt), .usb_connect(usb_connect),
  .lowpower_req(lowpower_req), .soft_reset(soft_reset), .wake_req(wake_req)
);

// File: tb/sim_busshare_ctl.sv
module sim_busshare_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 50;
  localparam int WAKE = 3;
  localparam int SETTLE = 2 * TICK + 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic share_en_in = 1'b1, mfg_mode = 1'b0, suspend_in = 1'b0, other_lp_cause = 1'b0;
  logic bus_oe, engine_halt, usb_connect, lowpower_req, soft_reset, wake_req;

  int checks = 0;
  int fails = 0;
  int soft_pulses = 0;
  int wakes = 0;

  typedef struct {
    string tag;
    logic  oe;
    logic  conn;
    logic  lp;
    logic  halt;
  } exp_t;
  exp_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  busshare_ctl #(.TICK_CYCLES(TICK), .WAKE_CYCLES(WAKE)) u0 (
    .clk(clk), .rst(rst), .share_en_in(share_en_in), .mfg_mode(mfg_mode),
    .suspend_in(suspend_in), .other_lp_cause(other_lp_cause),
    .bus_oe(bus_oe), .engine_halt(engine_halt), .usb_connect(usb_connect),
    .lowpower_req(lowpower_req), .soft_reset(soft_reset), .wake_req(wake_req)
  );

  task automatic push(input string tag, input logic oe, input logic conn,
                      input logic lp, input logic halt);
    exp_t e;
    e.tag = tag; e.oe = oe; e.conn = conn; e.lp = lp; e.halt = halt;
    sbq.push_back(e);
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected output sets and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (bus_oe !== e.oe || usb_connect !== e.conn ||
            lowpower_req !== e.lp || engine_halt !== e.halt) begin
          fails++;
          $display("FAIL %s: actual oe=%b conn=%b lp=%b halt=%b expected oe=%b conn=%b lp=%b halt=%b",
                   e.tag, bus_oe, usb_connect, lowpower_req, engine_halt,
                   e.oe, e.conn, e.lp, e.halt);
        end
      end
    end
  end

  // pulse monitor: soft_reset width and wake window length
  initial begin
    int wlen = 0;
    int slen = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (wake_req) wlen++;
        else if (wlen > 0) begin
          wakes++;
          check_int("R8 wake window length", wlen, WAKE);
          wlen = 0;
        end
        if (soft_reset) slen++;
        else if (slen > 0) begin
          soft_pulses++;
          check_int("R6 soft reset width", slen, 1);
          slen = 0;
        end
      end
    end
  end

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    push("R1 outputs in reset", 1'b0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    checks++;
    if (soft_reset !== 1'b0 || wake_req !== 1'b0) begin
      fails++;
      $display("FAIL R1 pulses in reset: actual soft=%b wake=%b expected 0 0", soft_reset, wake_req);
    end
    rst = 1'b0;
    push("R1 outputs after release", 1'b0, 1'b1, 1'b0, 1'b1);
    repeat (TICK - 5) @(negedge clk);
    push("R2 no drive before first sample", 1'b0, 1'b1, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    push("R2 drive after first sample", 1'b1, 1'b1, 1'b0, 1'b0);
    settle();

    share_en_in = 1'b0; settle();
    push("R5 low sample enters low power", 1'b0, 1'b0, 1'b1, 1'b1);

    other_lp_cause = 1'b1; share_en_in = 1'b1; settle();
    push("R7 other cause keeps low power", 1'b0, 1'b0, 1'b1, 1'b1);
    check_int("R7 no soft reset", soft_pulses, 0);

    other_lp_cause = 1'b0; settle();
    push("R6 exit low power", 1'b1, 1'b1, 1'b0, 1'b0);
    check_int("R6 one soft reset", soft_pulses, 1);

    mfg_mode = 1'b1; share_en_in = 1'b0; settle();
    push("R3 mfg mode ignores enable", 1'b1, 1'b1, 1'b0, 1'b0);
    mfg_mode = 1'b0; settle();
    push("R3 sampling resumes", 1'b0, 1'b0, 1'b1, 1'b1);
    share_en_in = 1'b1; settle();
    push("R6 second exit", 1'b1, 1'b1, 1'b0, 1'b0);
    check_int("R6 soft reset count", soft_pulses, 2);

    suspend_in = 1'b1; repeat (3) @(negedge clk);
    push("R9 suspend requests low power", 1'b1, 1'b1, 1'b1, 1'b0);
    settle();
    check_int("R9 no wake on matching sample", wakes, 0);
    share_en_in = 1'b0; settle();
    push("R8 suspended disable releases bus", 1'b0, 1'b1, 1'b1, 1'b1);
    check_int("R8 one wake", wakes, 1);
    settle();
    check_int("R9 no further wake", wakes, 1);
    share_en_in = 1'b1; settle();
    push("R8 suspended enable drives bus", 1'b1, 1'b1, 1'b1, 1'b0);
    check_int("R8 second wake", wakes, 2);
    check_int("R8 no soft reset in suspend", soft_pulses, 2);

    suspend_in = 1'b0; repeat (3) @(negedge clk);
    push("R9 resume clears low power", 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule